// File: doc/BRIEF.md
# Timekeeper Register Burst-Access Controller

This block sits behind the byte-level serial front end of a timekeeping device. The front end hands it one decoded command byte at the start of each transaction, then a stream of write data bytes or read requests. The block routes each access to one of two places: a small bank of clock registers, which holds the time fields, a control register and a charger setup register, or a 31-byte scratch RAM. A command either addresses one location, or asks for a burst that walks the selected bank from location 0.

The block enforces two commit rules. A burst write to the clock bank collects its bytes in a shadow buffer and copies all eight into the live registers in one cycle, but only once the eighth byte arrives. A burst write to RAM stores each byte as it arrives. A write-protect bit in the control register blocks every write except a write to the control register itself. When chip enable falls, the front end pulses an abort input. The abort ends the transaction and drops any partly filled shadow buffer.

Top module: `rtc_burst_access`

## Requirements
- R1: A command byte is accepted only when its bit 7 is 1. Bit 6 selects RAM (1) or the clock bank (0), bits 5:1 hold the address, and bit 0 selects read (1) or write (0). Address 31 means burst. A command byte with bit 7 at 0 ends the current transaction, and the data that follows is ignored.
- R2: After reset, rd_valid_o is 0 and every clock-bank location reads 0x00, including the control register, so write protect is off.
- R3: A rd_req_i pulse during a read transaction gives rd_valid_o high together with the data byte on the next cycle. A rd_req_i pulse outside a read transaction gives no rd_valid_o.
- R4: A single clock-bank write stores its byte at addresses 0 to 8. Writes to addresses 9 to 30 are discarded, and reads from those addresses return 0x00.
- R5: The control register is clock address 7. Its bit 7 is write protect and bits 6:0 always read 0. A single write to it is accepted whatever the state of write protect.
- R6: While write protect is 1, single writes to clock addresses other than 7 have no effect, and neither do clock-bank burst commits or RAM writes of any kind.
- R7: A burst read starts at location 0. It steps through clock addresses 0 to 7, or RAM addresses 0 to 30, then wraps back to 0.
- R8: A clock-bank burst write changes no live register until its eighth byte arrives. On that byte, bytes 0 to 7 go into addresses 0 to 7 in the same cycle, with the control register keeping only bit 7. Further bytes in the same burst are ignored.
- R9: An abort pulse ends the transaction. A clock-bank burst that had received fewer than eight bytes transfers nothing, and data arriving after the abort is ignored.
- R10: A RAM burst write stores byte k at RAM address k as soon as it arrives, even if the burst ends early. Bytes after the 31st are ignored.
- R11: Single RAM writes and reads use addresses 0 to 30 directly.
- R12: A wr_valid_i byte during a read transaction, or while no transaction is open, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_abort_i | input | 1 | Ends the transaction (chip enable fell) |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_byte_i | input | 8 | Command byte |
| wr_valid_i | input | 1 | Write data strobe |
| wr_byte_i | input | 8 | Write data byte |
| rd_req_i | input | 1 | Request for the next read byte |
| rd_valid_o | output | 1 | Read byte valid, one cycle after the request |
| rd_byte_o | output | 8 | Read data byte |

## Verification
On every cycle, the assertions check the following: the live clock registers hold still while write protect is set or a write targets an address with no storage, the control register's low bits read as zero, an abort empties the burst counter, and a read strobe appears only after a request inside a read transaction. Only the bench scenarios can show the rest. That covers the all-or-nothing clock burst commit, the per-byte RAM commit of a short burst, the wrap of burst reads, and the fact that bytes after a burst has completed are ignored. It also covers a command byte with bit 7 clear ending the transaction. A reference model run under directed and seeded random traffic compares every byte read back.

// File: rtl/rtc_burst_pkg.sv
package rtc_burst_pkg;
  parameter int DATA_W     = 8;
  parameter int ADDR_W     = 5;
  parameter int CLK_REGS   = 9;
  parameter int CLK_BURST  = 8;
  parameter int RAM_DEPTH  = 31;
  parameter int CTRL_ADDR  = 7;
  parameter int BURST_ADDR = 31;

  typedef struct packed {
    logic              valid;
    logic              rd;
    logic              ram;
    logic              burst;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_burst_pkg::*;
(
  input  logic [DATA_W-1:0] cmd_byte_i,
  output cmd_t              cmd_o
);
  always_comb begin
    cmd_o.valid = cmd_byte_i[DATA_W-1];
    cmd_o.ram   = cmd_byte_i[DATA_W-2];
    cmd_o.addr  = cmd_byte_i[ADDR_W:1];
    cmd_o.rd    = cmd_byte_i[0];
    cmd_o.burst = (cmd_byte_i[ADDR_W:1] == ADDR_W'(BURST_ADDR));
  end
endmodule

// File: rtl/rtc_xfer_seq.sv
module rtc_xfer_seq
  import rtc_burst_pkg::*;
#(
  parameter int IDX_W = $clog2(CLK_BURST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic              cmd_valid_i,
  input  cmd_t              cmd_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  input  logic              wp_i,
  output logic              clk_we_o,
  output logic [ADDR_W-1:0] clk_waddr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              sh_we_o,
  output logic [IDX_W-1:0]  sh_idx_o,
  output logic              commit_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_waddr_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_valid_o,
  output logic              rd_sel_ram_o
);
  localparam logic [ADDR_W-1:0] CLK_LAST = ADDR_W'(CLK_BURST - 1);
  localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_DEPTH - 1);

  logic              act_q, rd_q, ram_q, burst_q, done_q;
  logic [ADDR_W-1:0] addr_q, cnt_q;
  logic              wr_go, rd_go;
  logic [ADDR_W-1:0] last_idx, cur_addr;

  always_comb begin
    wr_go       = wr_valid_i && act_q && !rd_q && !abort_i && !cmd_valid_i;
    rd_go       = rd_req_i && act_q && rd_q && !abort_i && !cmd_valid_i;
    last_idx    = ram_q ? RAM_LAST : CLK_LAST;
    cur_addr    = burst_q ? cnt_q : addr_q;
    clk_we_o    = wr_go && !ram_q && !burst_q;
    clk_waddr_o = addr_q;
    wdata_o     = wr_data_i;
    sh_we_o     = wr_go && !ram_q && burst_q && !done_q;
    sh_idx_o    = cnt_q[IDX_W-1:0];
    commit_o    = sh_we_o && (cnt_q == CLK_LAST);
    ram_we_o    = wr_go && ram_q && !wp_i &&
                  (burst_q ? !done_q : (addr_q < ADDR_W'(RAM_DEPTH)));
    ram_waddr_o = cur_addr;
    rd_en_o     = rd_go;
    rd_addr_o   = cur_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      ram_q   <= 1'b0;
      burst_q <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
    end else if (abort_i) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cmd_valid_i) begin
      act_q   <= cmd_i.valid;
      rd_q    <= cmd_i.rd;
      ram_q   <= cmd_i.ram;
      burst_q <= cmd_i.burst;
      addr_q  <= cmd_i.addr;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (wr_go && burst_q && !done_q) begin
        if (cnt_q == last_idx) done_q <= 1'b1;
        else                   cnt_q  <= cnt_q + 1'b1;
      end
      if (rd_go && burst_q) begin
        cnt_q <= (cnt_q == last_idx) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o   <= 1'b0;
      rd_sel_ram_o <= 1'b0;
    end else begin
      rd_valid_o   <= rd_go;
      rd_sel_ram_o <= ram_q;
    end
  end

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!act_q && cnt_q == '0)); // R9
  AST_BURST_START_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid_i && !abort_i && cmd_i.valid && cmd_i.burst) |=> (cnt_q == '0)); // R7
  AST_CNT_IN_BANK: assert property (@(posedge clk) disable iff (rst)
    (act_q && !ram_q) |-> (cnt_q <= CLK_LAST)); // R7
  AST_NO_STRAY_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    !(rd_req_i && act_q && rd_q) |=> !rd_valid_o); // R3
  AST_RAM_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    ram_we_o |-> (ram_waddr_o <= RAM_LAST)); // R11
endmodule

// File: rtl/rtc_clock_bank.sv
module rtc_clock_bank
  import rtc_burst_pkg::*;
#(
  parameter int IDX_W = $clog2(CLK_BURST)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sh_we_i,
  input  logic [IDX_W-1:0]  sh_idx_i,
  input  logic              commit_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wp_o
);
  logic [CLK_REGS-1:0][DATA_W-1:0]  live_q;
  logic [CLK_BURST-1:0][DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0]                rd_sel;

  assign wp_o = live_q[CTRL_ADDR][DATA_W-1];

  // shadow buffer for clock burst writes, cleared on abort
  always_ff @(posedge clk) begin
    if (rst || abort_i) shadow_q <= '0;
    else if (sh_we_i)   shadow_q[sh_idx_i] <= wdata_i;
  end

  for (genvar i = 0; i < CLK_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK =
      (i == CTRL_ADDR) ? {1'b1, {(DATA_W-1){1'b0}}} : {DATA_W{1'b1}};
    localparam bit IS_CTRL = (i == CTRL_ADDR);
    logic commit_hit;
    if (i < CLK_BURST) begin : g_burst
      if (i == CLK_BURST - 1) begin : g_tail
        assign commit_hit = commit_i && !wp_o;
      end else begin : g_body
        assign commit_hit = commit_i && !wp_o;
      end
    end else begin : g_noburst
      assign commit_hit = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        live_q[i] <= '0;
      end else if (commit_hit) begin
        if (i == CLK_BURST - 1) live_q[i] <= wdata_i & MASK;
        else                    live_q[i] <= shadow_q[i % CLK_BURST] & MASK;
      end else if (we_i && waddr_i == ADDR_W'(i) && (IS_CTRL || !wp_o)) begin
        live_q[i] <= wdata_i & MASK;
      end
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int k = 0; k < CLK_REGS; k++) begin
      if (rd_addr_i == ADDR_W'(k)) rd_sel = live_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_sel;
  end

  AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_addr_i == ADDR_W'(CTRL_ADDR)) |=> (rdata_o[DATA_W-2:0] == '0)); // R5
  AST_WP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (wp_o && !(we_i && waddr_i == ADDR_W'(CTRL_ADDR))) |=> $stable(live_q)); // R6
  AST_NO_STORAGE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we_i && waddr_i >= ADDR_W'(CLK_REGS) && !commit_i) |=> $stable(live_q)); // R4
  AST_PARTIAL_BURST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sh_we_i && !commit_i && !we_i) |=> $stable(live_q)); // R8
endmodule

// File: rtl/rtc_ram_bank.sv
module rtc_ram_bank
  import rtc_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [RAM_DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= (rd_addr_i < ADDR_W'(RAM_DEPTH)) ? mem[rd_addr_i] : '0;
  end
endmodule

// File: rtl/rtc_burst_access.sv
module rtc_burst_access
  import rtc_burst_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_abort_i,
  input  logic              cmd_valid_i,
  input  logic [DATA_W-1:0] cmd_byte_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_byte_i,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_byte_o
);
  localparam int IDX_W = $clog2(CLK_BURST);

  cmd_t              cmd;
  logic              clk_we, sh_we, commit, ram_we, rd_en, rd_sel_ram, wp;
  logic [ADDR_W-1:0] clk_waddr, ram_waddr, rd_addr;
  logic [DATA_W-1:0] wdata, clk_rdata, ram_rdata;
  logic [IDX_W-1:0]  sh_idx;

  rtc_cmd_decode u_dec (.cmd_byte_i(cmd_byte_i), .cmd_o(cmd));

  rtc_xfer_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .abort_i(xfer_abort_i),
    .cmd_valid_i(cmd_valid_i), .cmd_i(cmd),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_byte_i),
    .rd_req_i(rd_req_i), .wp_i(wp),
    .clk_we_o(clk_we), .clk_waddr_o(clk_waddr), .wdata_o(wdata),
    .sh_we_o(sh_we), .sh_idx_o(sh_idx), .commit_o(commit),
    .ram_we_o(ram_we), .ram_waddr_o(ram_waddr),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_valid_o(rd_valid_o), .rd_sel_ram_o(rd_sel_ram)
  );

  rtc_clock_bank #(.IDX_W(IDX_W)) u_clk (
    .clk(clk), .rst(rst), .abort_i(xfer_abort_i),
    .we_i(clk_we), .waddr_i(clk_waddr), .wdata_i(wdata),
    .sh_we_i(sh_we), .sh_idx_i(sh_idx), .commit_i(commit),
    .rd_en_i(rd_en && !rd_sel_ram_next()), .rd_addr_i(rd_addr),
    .rdata_o(clk_rdata), .wp_o(wp)
  );

  function automatic logic rd_sel_ram_next();
    return cmd_ram_q;
  endfunction

  logic cmd_ram_q;
  always_ff @(posedge clk) begin
    if (rst) cmd_ram_q <= 1'b0;
    else if (cmd_valid_i && !xfer_abort_i) cmd_ram_q <= cmd.ram;
  end

  rtc_ram_bank u_ram (
    .clk(clk), .rst(rst),
    .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(wdata),
    .rd_en_i(rd_en && cmd_ram_q), .rd_addr_i(rd_addr),
    .rdata_o(ram_rdata)
  );

  assign rd_byte_o = rd_sel_ram ? ram_rdata : clk_rdata;
endmodule

// File: tb/rtc_burst_access_tb.sv
module rtc_burst_access_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       abort_i = 1'b0, cmd_valid = 1'b0, wr_valid = 1'b0, rd_req = 1'b0;
  logic [7:0] cmd_byte = '0, wr_byte = '0;
  logic       rd_valid;
  logic [7:0] rd_byte;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] clk_m [9];
  logic [7:0] ram_m [31];

  rtc_burst_access u_dut (
    .clk(clk), .rst(rst), .xfer_abort_i(abort_i),
    .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte),
    .wr_valid_i(wr_valid), .wr_byte_i(wr_byte),
    .rd_req_i(rd_req), .rd_valid_o(rd_valid), .rd_byte_o(rd_byte)
  );

  always #4 clk = ~clk;

  function automatic logic [7:0] mk_cmd(bit rd, bit ram, logic [4:0] a);
    return {1'b1, ram, a, rd};
  endfunction

  function automatic bit wp_m();
    return clk_m[7][7];
  endfunction

  function automatic logic [7:0] exp_clk(int a);
    return (a < 9) ? clk_m[a] : 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cmd_valid = 0; wr_valid = 0; rd_req = 0; abort_i = 0;
  endtask

  task automatic send_cmd(logic [7:0] b);
    cmd_byte = b; cmd_valid = 1; tick();
  endtask

  task automatic send_wr(logic [7:0] b);
    wr_byte = b; wr_valid = 1; tick();
  endtask

  task automatic do_abort();
    abort_i = 1; tick();
  endtask

  task automatic do_read(output logic v, output logic [7:0] d);
    rd_req = 1; tick();
    v = rd_valid; d = rd_byte;
  endtask

  task automatic model_clk_wr(int a, logic [7:0] d);
    if (a == 7) clk_m[7] = {d[7], 7'b0};
    else if (a < 9 && !wp_m()) clk_m[a] = d;
  endtask

  task automatic wr_clk(int a, logic [7:0] d);
    send_cmd(mk_cmd(0, 0, 5'(a))); send_wr(d); do_abort();
    model_clk_wr(a, d);
  endtask

  task automatic wr_ram(int a, logic [7:0] d);
    send_cmd(mk_cmd(0, 1, 5'(a))); send_wr(d); do_abort();
    if (!wp_m()) ram_m[a] = d;
  endtask

  task automatic chk_clk(string tag, int a);
    logic v; logic [7:0] d;
    send_cmd(mk_cmd(1, 0, 5'(a))); do_read(v, d); do_abort();
    chk({tag, " valid"}, {7'b0, v}, 8'h01);
    chk(tag, d, exp_clk(a));
  endtask

  task automatic chk_ram(string tag, int a);
    logic v; logic [7:0] d;
    send_cmd(mk_cmd(1, 1, 5'(a))); do_read(v, d); do_abort();
    chk(tag, d, ram_m[a]);
  endtask

  task automatic clk_burst(int n, bit ab);
    logic [7:0] b [8];
    bit pwp;
    pwp = wp_m();
    send_cmd(mk_cmd(0, 0, 5'd31));
    for (int i = 0; i < n; i++) begin
      logic [7:0] x;
      x = 8'($urandom);
      if (i == 7) x[7] = ($urandom % 4 == 0);
      if (i < 8) b[i] = x;
      send_wr(x);
    end
    if (ab) do_abort();
    if (n >= 8 && !pwp) begin
      for (int i = 0; i < 7; i++) clk_m[i] = b[i];
      clk_m[7] = {b[7][7], 7'b0};
    end
  endtask

  task automatic ram_burst(int n);
    send_cmd(mk_cmd(0, 1, 5'd31));
    for (int i = 0; i < n; i++) begin
      logic [7:0] x;
      x = 8'($urandom);
      send_wr(x);
      if (i < 31 && !wp_m()) ram_m[i] = x;
    end
    do_abort();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic v; logic [7:0] d;
    void'($urandom(32'h5eed1302));
    for (int i = 0; i < 9; i++) clk_m[i] = 8'h00;
    for (int i = 0; i < 31; i++) ram_m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R2 reset state
    chk("R2 rd_valid at reset", {7'b0, rd_valid}, 8'h00);
    chk_clk("R2 ctrl after reset", 7);
    chk_clk("R2 seconds after reset", 0);
    // R3 no read strobe while idle
    do_read(v, d);
    chk("R3 idle rd_req", {7'b0, v}, 8'h00);

    // R1 / R4 single clock writes 0..8
    for (int a = 0; a < 9; a++) if (a != 7) wr_clk(a, 8'($urandom));
    for (int a = 0; a < 9; a++) chk_clk("R4 single clock readback", a);
    wr_clk(12, 8'h5a);
    chk_clk("R4 no-storage read", 12);

    // R5 control bits; R6 write protect
    wr_clk(7, 8'hff);
    chk_clk("R5 ctrl low bits zero", 7);
    wr_clk(2, 8'h33);
    chk_clk("R6 clock write blocked", 2);
    wr_ram(4, 8'h77);
    wr_clk(7, 8'h00);

    // R10 full RAM burst with extra bytes; R7 wrap on read
    ram_burst(33);
    send_cmd(mk_cmd(1, 1, 5'd31));
    for (int i = 0; i < 32; i++) begin
      do_read(v, d);
      chk("R7 R10 ram burst read", d, ram_m[i % 31]);
    end
    do_abort();
    chk_ram("R6 R11 ram single", 4);

    // R10 short RAM burst
    ram_burst(10);
    for (int i = 0; i < 11; i++) chk_ram("R10 short ram burst", i);

    // R9 partial clock burst transfers nothing; R8 full burst
    clk_burst(7, 1);
    for (int a = 0; a < 8; a++) chk_clk("R9 partial clock burst", a);
    clk_burst(10, 1);
    send_cmd(mk_cmd(1, 0, 5'd31));
    for (int i = 0; i < 9; i++) begin
      do_read(v, d);
      chk("R7 R8 clock burst read", d, exp_clk(i % 8));
    end
    do_abort();

    // R12 data in read transaction and idle ignored
    send_cmd(mk_cmd(1, 0, 5'd1)); send_wr(8'hc3); do_abort();
    send_wr(8'h3c);
    chk_clk("R12 write in read ignored", 1);
    // R1 command with bit7 clear ends transaction
    send_cmd(mk_cmd(0, 0, 5'd1)); send_cmd(8'h02); send_wr(8'h99); do_abort();
    chk_clk("R1 invalid command", 1);
    // R9 data after abort ignored
    send_cmd(mk_cmd(0, 1, 5'd5)); do_abort(); send_wr(8'h11);
    chk_ram("R9 after abort", 5);

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom % 6;
      case (op)
        0: begin
          int a; a = $urandom % 16;
          if (a == 7 && ($urandom % 2)) a = 3;
          wr_clk(a, 8'($urandom));
        end
        1: wr_ram($urandom % 31, 8'($urandom));
        2: chk_clk("R4 R5 R6 random clock", $urandom % 16);
        3: chk_ram("R6 R11 random ram", $urandom % 31);
        4: clk_burst($urandom % 11, 1);
        default: ram_burst(1 + $urandom % 34);
      endcase
      if (wp_m() && ($urandom % 3 == 0)) wr_clk(7, 8'h00);
    end
    for (int a = 0; a < 9; a++) chk_clk("R8 final clock", a);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule